// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width-modulated outputs, each programmed through a small synchronous register bus. Every channel divides the input clock by a programmable prescale factor to form counter steps. It counts those steps through a period of programmable length and drives its output high for a programmable number of steps at the start of each period.

Software writes the step divider and the period length first. It then writes the high-time register, and that write commits all three values together. While a channel runs, a commit waits for the running period to end, so no period ever mixes two configurations. Clearing the enable bit is different: it stops the channel on the next clock edge, drives its output low and rewinds its counters, so a later enable starts a clean period from step zero.

Each channel occupies a 32-byte window, with the window base at the channel index shifted left by five. Bus writes take one cycle. Read data appears on the cycle after the request.

Top module: `pwm_bank`

## Requirements
- R1: Channel c is addressed at byte address c*32 plus an offset: 0x00 is the 8-bit step divider, 0x04 the 8-bit period length, 0x08 the 16-bit high time, and 0x18 holds the run bit in bit 0. A read returns the last written value, masked to its field width and zero-extended, on rsp_rdata in the cycle after the request. rsp_rdata is zero in every cycle that does not follow a read request.
- R2: A running channel advances one step every divider+1 clock cycles. Its period lasts (divider+1)*length cycles. Its output is high for the first (divider+1)*high cycles of each period, and the first period after enabling starts at step zero on the cycle after the enabling write.
- R3: Writing the step divider or the period length without a following high-time write leaves the output waveform unchanged.
- R4: A high-time write commits the divider, length and high-time values together. On a stopped channel the commit happens at the next edge. On a running channel it happens at the end of the running period. A high-time write accepted on the very edge that ends a period takes effect at the end of the following period.
- R5: Writing 0 to the run bit drives the output low from the next cycle, without finishing the period. A later write of 1 restarts from step zero.
- R6: A committed high time of 0 keeps the output low. A high time greater than or equal to the period length keeps it high for the whole period. A period length of 0 behaves as a length of 1.
- R7: Offsets other than the four listed, and channel windows with index 4 or above, ignore writes and read as zero.
- R8: After reset all registers are zero, all outputs are low and rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read request |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Two events can land on the same clock edge: a high-time write that arms a commit, and the edge that closes a period. The bench issues the write exactly on a period-closing edge. It then checks that the following full period still carries the old high time and that the period after it carries the new one. A stop write is likewise placed on a period-closing edge, and the output must be low on the very next cycle even though a fresh period would otherwise have begun high.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // byte offsets inside one channel window
  localparam int unsigned OFF_DIVIDER = 'h00;
  localparam int unsigned OFF_LENGTH  = 'h04;
  localparam int unsigned OFF_HIGH    = 'h08;
  localparam int unsigned OFF_RUN     = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIV,
    SEL_LEN,
    SEL_HIGH,
    SEL_RUN
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input int unsigned off);
    case (off)
      OFF_DIVIDER: return SEL_DIV;
      OFF_LENGTH:  return SEL_LEN;
      OFF_HIGH:    return SEL_HIGH;
      OFF_RUN:     return SEL_RUN;
      default:     return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pwm_bank_cfg.sv
module pwm_bank_cfg
  import pwm_bank_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 8,
  parameter int HIGH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          wr_sel,
  input  logic [HIGH_W-1:0] wr_data,
  input  logic              period_end,
  output logic [DIV_W-1:0]  div_pend,
  output logic [LEN_W-1:0]  len_pend,
  output logic [HIGH_W-1:0] high_pend,
  output logic              run,
  output logic [DIV_W-1:0]  div_act,
  output logic [LEN_W-1:0]  len_act,
  output logic [HIGH_W-1:0] high_act
);

  logic [DIV_W-1:0]  div_pend_n, div_act_n;
  logic [LEN_W-1:0]  len_pend_n, len_act_n;
  logic [HIGH_W-1:0] high_pend_n, high_act_n;
  logic              run_n, armed_q, armed_n, commit;

  // a commit lands when idle or on the closing edge of a period
  assign commit = armed_q && (!run || period_end);

  always_comb begin
    div_pend_n  = div_pend;
    len_pend_n  = len_pend;
    high_pend_n = high_pend;
    run_n       = run;
    armed_n     = armed_q;
    div_act_n   = div_act;
    len_act_n   = len_act;
    high_act_n  = high_act;
    if (commit) begin
      div_act_n  = div_pend;
      len_act_n  = len_pend;
      high_act_n = high_pend;
      armed_n    = 1'b0;
    end
    case (wr_sel)
      SEL_DIV:  div_pend_n = wr_data[DIV_W-1:0];
      SEL_LEN:  len_pend_n = wr_data[LEN_W-1:0];
      SEL_HIGH: begin
        high_pend_n = wr_data;
        armed_n     = 1'b1;
      end
      SEL_RUN:  run_n = wr_data[0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pend  <= '0;
      len_pend  <= '0;
      high_pend <= '0;
      run       <= 1'b0;
      armed_q   <= 1'b0;
      div_act   <= '0;
      len_act   <= '0;
      high_act  <= '0;
    end else begin
      div_pend  <= div_pend_n;
      len_pend  <= len_pend_n;
      high_pend <= high_pend_n;
      run       <= run_n;
      armed_q   <= armed_n;
      div_act   <= div_act_n;
      len_act   <= len_act_n;
      high_act  <= high_act_n;
    end
  end

endmodule

// File: rtl/pwm_bank_gen.sv
module pwm_bank_gen #(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 8,
  parameter int HIGH_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_act,
  input  logic [LEN_W-1:0]  len_act,
  input  logic [HIGH_W-1:0] high_act,
  output logic              period_end,
  output logic              wave
);

  logic [DIV_W-1:0] pre_q, pre_n;
  logic [LEN_W-1:0] step_q, step_n, last_step;
  logic             step_tick;

  // a zero length is handled as one step per period
  assign last_step  = (len_act == '0) ? '0 : len_act - 1'b1;
  assign step_tick  = (pre_q == div_act);
  assign period_end = run && step_tick && (step_q == last_step);
  assign wave       = run && (HIGH_W'(step_q) < high_act);

  always_comb begin
    pre_n  = pre_q;
    step_n = step_q;
    if (!run) begin
      pre_n  = '0;
      step_n = '0;
    end else if (step_tick) begin
      pre_n  = '0;
      step_n = (step_q == last_step) ? '0 : step_q + 1'b1;
    end else begin
      pre_n  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q  <= pre_n;
      step_q <= step_n;
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CH_SHIFT = 5,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 8,
  parameter int HIGH_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int CH_FIELD_W = ADDR_W - CH_SHIFT;

  logic [CH_FIELD_W-1:0] req_ch;
  logic                  ch_hit;
  reg_sel_e              req_sel;
  logic [DATA_W-1:0]     rd_next;
  logic                  unused_wdata_hi;

  logic [NUM_CH-1:0]     ch_run, ch_end;
  reg_sel_e              ch_wsel      [NUM_CH];
  logic [DIV_W-1:0]      ch_div_pend  [NUM_CH];
  logic [LEN_W-1:0]      ch_len_pend  [NUM_CH];
  logic [HIGH_W-1:0]     ch_high_pend [NUM_CH];
  logic [DIV_W-1:0]      ch_div_act   [NUM_CH];
  logic [LEN_W-1:0]      ch_len_act   [NUM_CH];
  logic [HIGH_W-1:0]     ch_high_act  [NUM_CH];

  assign req_ch          = req_addr[ADDR_W-1:CH_SHIFT];
  assign ch_hit          = int'(req_ch) < NUM_CH;
  assign req_sel         = decode_off(int'(req_addr[CH_SHIFT-1:0]));
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:HIGH_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_wsel[i] = (req_valid && req_write && ch_hit &&
                         req_ch == CH_FIELD_W'(i)) ? req_sel : SEL_NONE;

    pwm_bank_cfg #(.DIV_W(DIV_W), .LEN_W(LEN_W), .HIGH_W(HIGH_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (ch_wsel[i]),
      .wr_data    (req_wdata[HIGH_W-1:0]),
      .period_end (ch_end[i]),
      .div_pend   (ch_div_pend[i]),
      .len_pend   (ch_len_pend[i]),
      .high_pend  (ch_high_pend[i]),
      .run        (ch_run[i]),
      .div_act    (ch_div_act[i]),
      .len_act    (ch_len_act[i]),
      .high_act   (ch_high_act[i])
    );

    pwm_bank_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W), .HIGH_W(HIGH_W)) u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ch_run[i]),
      .div_act    (ch_div_act[i]),
      .len_act    (ch_len_act[i]),
      .high_act   (ch_high_act[i]),
      .period_end (ch_end[i]),
      .wave       (pwm_out[i])
    );
  end

  // read data path: next value, then register
  always_comb begin
    rd_next = '0;
    if (req_valid && !req_write && ch_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (int'(req_ch) == i) begin
          case (req_sel)
            SEL_DIV:  rd_next = DATA_W'(ch_div_pend[i]);
            SEL_LEN:  rd_next = DATA_W'(ch_len_pend[i]);
            SEL_HIGH: rd_next = DATA_W'(ch_high_pend[i]);
            SEL_RUN:  rd_next = DATA_W'(ch_run[i]);
            default:  rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else        rsp_rdata <= rd_next;
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CH_SHIFT = 5,
  parameter int HIGH_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_end,
  input logic [HIGH_W-1:0] ch_high_act [NUM_CH]
);

  // R7: a read at an unmapped offset returns zero
  a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write &&
     decode_off(int'(req_addr[CH_SHIFT-1:0])) == SEL_NONE) |=> rsp_rdata == '0);

  // R7: a read beyond the last channel window returns zero
  a_r7_window_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && int'(req_addr[ADDR_W-1:CH_SHIFT]) >= NUM_CH)
      |=> rsp_rdata == '0);

  // R1: no read request, no read data
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> rsp_rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5: clearing the run bit silences the output on the next cycle
    a_r5_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_wdata[0] &&
       req_addr == ADDR_W'((i << CH_SHIFT) + OFF_RUN)) |=> !pwm_out[i]);

    // R4: committed high time moves only when idle or at a period end
    a_r4_commit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_high_act[i]) |-> $past(!ch_run[i] || ch_end[i]));

    // R6: a committed high time of zero keeps the output low
    a_r6_zero_high_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_high_act[i] == '0) |-> !pwm_out[i]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CH_SHIFT(CH_SHIFT), .HIGH_W(HIGH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_rdata  (rsp_rdata),
  .pwm_out    (pwm_out),
  .ch_run     (ch_run),
  .ch_end     (ch_end),
  .ch_high_act(ch_high_act)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0]  pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t rd_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .pwm_out(pwm_out)
  );

  function automatic void chk(input string tag, input logic [31:0] act,
                              input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // monitor: pops the scoreboard whenever read data is due
  always @(posedge clk) rd_seen <= rst_n && req_valid && !req_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) chk("R1 unexpected read data", 32'd1, 32'd0);
      else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.tag, rsp_rdata, it.exp);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    rd_q.push_back('{exp, tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // samples the current cycle and n-1 more, leaves at the next unsampled one
  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      if (pwm_out[ch]) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk("R8 outputs after reset", {28'd0, pwm_out}, 32'd0);
    chk("R8 read data after reset", rsp_rdata, 32'd0);
    rd(8'h00, 32'd0, "R8 divider resets to zero");
    rd(8'h48, 32'd0, "R8 high time resets to zero");

    // R1 field masking and readback on channel 3
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h0000_00FF, "R1 divider masked to 8 bits");
    wr(8'h64, 32'h0000_01FF);
    rd(8'h64, 32'h0000_00FF, "R1 length masked to 8 bits");
    wr(8'h68, 32'h1234_5678);
    rd(8'h68, 32'h0000_5678, "R1 high time masked to 16 bits");
    chk("R1 channel 3 stays stopped", {31'd0, pwm_out[3]}, 32'd0);

    // R7 holes and windows beyond the last channel
    wr(8'h0C, 32'hFF);
    rd(8'h0C, 32'd0, "R7 unmapped offset reads zero");
    wr(8'h7C, 32'h1);
    rd(8'h78, 32'd0, "R7 unmapped write left run bit clear");
    wr(8'h98, 32'h1);
    wr(8'h80, 32'h55);
    rd(8'h80, 32'd0, "R7 fifth window reads zero");
    chk("R7 outputs untouched", {28'd0, pwm_out}, 32'd0);

    // R2 channel 0: divider 1, length 4, high 1 -> period 8, high 2
    wr(8'h00, 32'd1);
    wr(8'h04, 32'd4);
    wr(8'h08, 32'd1);
    wr(8'h18, 32'd1);
    chk("R2 first cycle after enable is high", {31'd0, pwm_out[0]}, 32'd1);
    count_high(0, 16, hi);
    chk("R2 high cycles over two periods", hi, 32'd4);
    rd(8'h18, 32'd1, "R1 run bit reads back");

    // R3 divider/length writes without a commit change nothing
    wr(8'h04, 32'd8);
    wr(8'h00, 32'd3);
    count_high(0, 16, hi);
    chk("R3 waveform unchanged without commit", hi, 32'd4);
    rd(8'h04, 32'd8, "R1 pending length visible on read");

    // R6 channel 1: high >= length, then zero, then length zero
    wr(8'h20, 32'd0);
    wr(8'h24, 32'd5);
    wr(8'h28, 32'd7);
    wr(8'h38, 32'd1);
    count_high(1, 10, hi);
    chk("R6 high >= length stays high", hi, 32'd10);
    wr(8'h28, 32'd0);
    repeat (6) @(negedge clk);
    count_high(1, 10, hi);
    chk("R6 high zero stays low", hi, 32'd0);
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd1);
    repeat (6) @(negedge clk);
    count_high(1, 10, hi);
    chk("R6 length zero acts as one", hi, 32'd10);

    // R4 channel 2: divider 0, length 8, high 2
    wr(8'h40, 32'd0);
    wr(8'h44, 32'd8);
    wr(8'h48, 32'd2);
    wr(8'h58, 32'd1);
    count_high(2, 2, hi);                 // steps 0,1
    chk("R2 channel 2 opening steps high", hi, 32'd2);
    wr(8'h48, 32'd6);                     // lands mid-period
    count_high(2, 5, hi);                 // steps 3..7 of the old period
    chk("R4 commit waits for period end", hi, 32'd0);
    count_high(2, 8, hi);
    chk("R4 new high time after boundary", hi, 32'd6);

    // R5 stop on a period-closing edge
    count_high(2, 7, hi);                 // now at step 7
    wr(8'h58, 32'd0);
    chk("R5 output low right after stop", {31'd0, pwm_out[2]}, 32'd0);
    count_high(2, 4, hi);
    chk("R5 stays low while stopped", hi, 32'd0);
    rd(8'h58, 32'd0, "R5 run bit reads clear");
    wr(8'h58, 32'd1);
    chk("R5 restart begins high at step zero", {31'd0, pwm_out[2]}, 32'd1);
    count_high(2, 8, hi);
    chk("R5 restart full period", hi, 32'd6);

    // R4 high-time write on the very edge closing a period
    count_high(2, 7, hi);                 // now at step 7
    wr(8'h48, 32'd3);
    count_high(2, 8, hi);
    chk("R4 same-edge write keeps old period", hi, 32'd6);
    count_high(2, 8, hi);
    chk("R4 same-edge write applied one period later", hi, 32'd3);

    // R3 channel 0 still on its original settings
    count_high(0, 16, hi);
    chk("R3 channel 0 unaffected", hi, 32'd4);

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", rd_q.size(), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule